// File: doc/BRIEF.md
# Serial Flash Read Controller

This block is the host end of a serial flash read. A client asks for a read by giving a 24-bit start address, a byte count and one of three read styles. The block then lowers chip select and runs a serial clock divided down from the system clock. It sends the command byte, the address and, for the two faster styles, one filler byte. After that it collects the returned data, one bit per serial clock or two bits per serial clock in the dual style. The block rebuilds whole bytes from this data and hands them over on a valid/ready stream. A one-cycle done pulse closes each request.

The one shared data pin (io0) carries the command and the address from the host. In the dual style, after the address has gone out, the host releases io0 and the device drives it with the low bit of each bit pair. The device output pin (io1) always carries the high bit of each pair. If the consumer of the stream is not ready, the serial clock is held low, so no byte is lost. A read may run past the end of the device array, because the device wraps its address to zero and adds no extra cycles.

Top module: `sfr_read_ctrl`

## Requirements
- R1: The first byte shifted out on io0 is the command, sent most significant bit first. Style code 1 sends 0x0B, style code 2 sends 0x3B, and style codes 0 and 3 send 0x03.
- R2: The 24 bits of `req_addr` follow the command on io0, most significant bit first.
- R3: Styles 1 and 2 insert 8 filler clocks after the address and style 0/3 inserts none, so a transfer of N bytes takes exactly 32 (+8) + N·8 (or N·4 in dual) rising serial clock edges.
- R4: In styles 0, 1 and 3, each byte is built from io1 sampled on 8 successive rising edges, the first sample being bit 7.
- R5: In style 2, each rising edge yields two bits, io1 carrying the higher bit and io0 the lower. Four edges make one byte, the first pair being bits 7 and 6.
- R6: `fl_io0_oe` is high from chip select assertion through the last address bit. In style 2 it goes low at the falling edge that starts the filler byte and stays low for the rest of the transfer. In the other styles it stays high until chip select is released.
- R7: The serial clock is low whenever chip select is high. While chip select is low, io0 output data changes only on a falling serial clock edge.
- R8: While `dout_valid` is high and `dout_ready` is low, the serial clock makes no rising edge.
- R9: Exactly max(`req_len`,1) bytes are delivered in address order. A held byte keeps its value until it is taken. `done` pulses once, after chip select has risen and the last byte has been taken.
- R10: `req_ready` is high only while the block is idle, and a request presented while busy has no effect. Chip select stays high for at least DIV system cycles between transfers.
- R11: A read that crosses the device array end continues without extra serial clocks, and the data returned after the wrap is taken in stream order.
- R12: After reset, chip select is high, the serial clock is low, io0 is not driven, `dout_valid` and `done` are low, and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Block is idle and takes the request |
| req_addr | input | 24 | Start byte address |
| req_len | input | LEN_W | Number of bytes to read (0 is taken as 1) |
| req_mode | input | 2 | Read style: 0 normal, 1 fast, 2 dual, 3 normal |
| dout_valid | output | 1 | A read byte is available |
| dout_ready | input | 1 | Consumer takes the byte |
| dout_data | output | 8 | Read byte |
| done | output | 1 | One-cycle end-of-request pulse |
| fl_sck | output | 1 | Serial clock to the flash |
| fl_cs_n | output | 1 | Active-low chip select |
| fl_io0_o | output | 1 | Host output value for io0 |
| fl_io0_oe | output | 1 | Host drive enable for io0 |
| fl_io0_i | input | 1 | io0 value read back (low bit in dual) |
| fl_io1_i | input | 1 | Flash data output (high bit in dual) |

## Verification
A wrong command or address counter shows on the very next transfer. The flash model then decodes an unexpected command byte or address, and the count of rising edges per transfer no longer matches 32/40 plus the data clocks. A slip in the bit-pair counter or in the byte assembler corrupts the first returned byte, which shows within eight serial clocks of the data phase. A fault in the drive enable or in the stall hold shows at the pins within one serial clock period, as contention on io0 in dual data or as a clock edge taken while a byte is held.

// File: rtl/sfr_pkg.sv
package sfr_pkg;

    localparam int ADDR_W = 24;
    localparam int CMD_W  = 8;
    localparam int HDR_W  = CMD_W + ADDR_W + 8;

    typedef enum logic [1:0] {
        RD_NORMAL = 2'd0,
        RD_FAST   = 2'd1,
        RD_DUAL   = 2'd2,
        RD_ALT    = 2'd3
    } rd_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_GAP  = 2'd2
    } ctl_state_e;

    typedef struct packed {
        logic       dual;
        logic [5:0] hdr_clks;
    } xfer_cfg_t;

    function automatic logic [CMD_W-1:0] cmd_opcode(rd_mode_e m);
        case (m)
            RD_FAST: return 8'h0B;
            RD_DUAL: return 8'h3B;
            default: return 8'h03;
        endcase
    endfunction

    function automatic xfer_cfg_t mode_cfg(rd_mode_e m);
        xfer_cfg_t c;
        c.dual     = (m == RD_DUAL);
        c.hdr_clks = (m == RD_FAST || m == RD_DUAL) ? 6'd40 : 6'd32;
        return c;
    endfunction

endpackage

// File: rtl/sfr_tick_gen.sv
module sfr_tick_gen #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic hold,
    output logic tick
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt_q;

    assign tick = run && !hold && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (!hold) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/sfr_tx_shift.sv
module sfr_tx_shift #(
    parameter int W = 40
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_word,
    input  logic         shift,
    output logic         bit_o
);
    logic [W-1:0] sr_q;

    assign bit_o = sr_q[W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q <= '0;
        end else if (load) begin
            sr_q <= load_word;
        end else if (shift) begin
            sr_q <= {sr_q[W-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/sfr_rx_assemble.sv
module sfr_rx_assemble (
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       sample,
    input  logic       dual,
    input  logic       hi_bit_i,
    input  logic       lo_bit_i,
    output logic [7:0] byte_next,
    output logic       byte_last
);
    logic [7:0] sr_q;
    logic [2:0] cnt_q;
    logic       at_end;

    always_comb begin
        if (dual) begin
            byte_next = {sr_q[5:0], hi_bit_i, lo_bit_i};
            at_end    = (cnt_q == 3'd3);
        end else begin
            byte_next = {sr_q[6:0], hi_bit_i};
            at_end    = (cnt_q == 3'd7);
        end
        byte_last = sample && at_end;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            sr_q  <= '0;
            cnt_q <= '0;
        end else if (sample) begin
            sr_q  <= byte_next;
            cnt_q <= at_end ? 3'd0 : cnt_q + 3'd1;
        end
    end
endmodule

// File: rtl/sfr_read_ctrl.sv
module sfr_read_ctrl
    import sfr_pkg::*;
#(
    parameter int DIV   = 4,
    parameter int LEN_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [23:0]       req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [1:0]        req_mode,
    output logic              dout_valid,
    input  logic              dout_ready,
    output logic [7:0]        dout_data,
    output logic              done,
    output logic              fl_sck,
    output logic              fl_cs_n,
    output logic              fl_io0_o,
    output logic              fl_io0_oe,
    input  logic              fl_io0_i,
    input  logic              fl_io1_i
);
    localparam int HALF  = DIV / 2;
    localparam int GAP_W = $clog2(DIV + 1);
    localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(DIV - 1);
    localparam logic [5:0] ADDR_END = 6'(CMD_W + ADDR_W);

    ctl_state_e          state_q;
    xfer_cfg_t           cfg_q;
    logic                sck_q, cs_n_q, oe_q, in_data_q, ending_q;
    logic                dv_q, done_q;
    logic [7:0]          dd_q;
    logic [5:0]          hdr_cnt_q;
    logic [LEN_W-1:0]    left_q;
    logic [GAP_W-1:0]    gap_q;

    logic                accept, stall, tick, rise, fall;
    logic [7:0]          byte_next;
    logic                byte_last;
    rd_mode_e            mode_in;
    logic [HDR_W-1:0]    hdr_word;

    assign mode_in  = rd_mode_e'(req_mode);
    assign hdr_word = {cmd_opcode(mode_in), req_addr, 8'h00};
    assign accept   = req_valid && (state_q == ST_IDLE);
    assign stall    = dv_q && !dout_ready;
    assign rise     = tick && !sck_q;
    assign fall     = tick && sck_q;

    sfr_tick_gen #(.HALF(HALF)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .run  (state_q == ST_XFER),
        .hold (stall && !sck_q),
        .tick (tick)
    );

    sfr_tx_shift #(.W(HDR_W)) u_tx (
        .clk       (clk),
        .rst       (rst),
        .load      (accept),
        .load_word (hdr_word),
        .shift     (fall && !in_data_q && !ending_q),
        .bit_o     (fl_io0_o)
    );

    sfr_rx_assemble u_rx (
        .clk       (clk),
        .rst       (rst),
        .clr       (accept),
        .sample    (rise && in_data_q),
        .dual      (cfg_q.dual),
        .hi_bit_i  (fl_io1_i),
        .lo_bit_i  (fl_io0_i),
        .byte_next (byte_next),
        .byte_last (byte_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            cfg_q     <= '0;
            sck_q     <= 1'b0;
            cs_n_q    <= 1'b1;
            oe_q      <= 1'b0;
            in_data_q <= 1'b0;
            ending_q  <= 1'b0;
            dv_q      <= 1'b0;
            dd_q      <= '0;
            done_q    <= 1'b0;
            hdr_cnt_q <= '0;
            left_q    <= '0;
            gap_q     <= '0;
        end else begin
            done_q <= 1'b0;
            if (dv_q && dout_ready) begin
                dv_q <= 1'b0;
            end
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        cs_n_q    <= 1'b0;
                        oe_q      <= 1'b1;
                        cfg_q     <= mode_cfg(mode_in);
                        hdr_cnt_q <= '0;
                        in_data_q <= 1'b0;
                        ending_q  <= 1'b0;
                        left_q    <= (req_len == '0) ? LEN_W'(1) : req_len;
                        state_q   <= ST_XFER;
                    end
                end
                ST_XFER: begin
                    if (rise) begin
                        sck_q <= 1'b1;
                        if (in_data_q) begin
                            if (byte_last) begin
                                dv_q   <= 1'b1;
                                dd_q   <= byte_next;
                                left_q <= left_q - 1'b1;
                                if (left_q == LEN_W'(1)) begin
                                    ending_q <= 1'b1;
                                end
                            end
                        end else begin
                            hdr_cnt_q <= hdr_cnt_q + 6'd1;
                            if (hdr_cnt_q == cfg_q.hdr_clks - 6'd1) begin
                                in_data_q <= 1'b1;
                            end
                        end
                    end else if (fall) begin
                        sck_q <= 1'b0;
                        if (ending_q) begin
                            cs_n_q  <= 1'b1;
                            oe_q    <= 1'b0;
                            gap_q   <= '0;
                            state_q <= ST_GAP;
                        end else if (cfg_q.dual && hdr_cnt_q == ADDR_END) begin
                            oe_q <= 1'b0;
                        end
                    end
                end
                ST_GAP: begin
                    if (gap_q >= GAP_LAST && !dv_q) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end else if (gap_q < GAP_LAST) begin
                        gap_q <= gap_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign req_ready  = (state_q == ST_IDLE);
    assign dout_valid = dv_q;
    assign dout_data  = dd_q;
    assign done       = done_q;
    assign fl_sck     = sck_q;
    assign fl_cs_n    = cs_n_q;
    assign fl_io0_oe  = oe_q;

endmodule

// File: rtl/sfr_read_ctrl_chk.sv
module sfr_read_ctrl_chk #(
    parameter int DIV = 4
) (
    input logic       clk,
    input logic       rst,
    input logic       req_ready,
    input logic       dout_valid,
    input logic       dout_ready,
    input logic [7:0] dout_data,
    input logic       done,
    input logic       fl_sck,
    input logic       fl_cs_n,
    input logic       fl_io0_o
);
    localparam int GW = $clog2(DIV + 1);
    logic [GW-1:0] hi_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_cnt <= GW'(DIV);
        end else if (!fl_cs_n) begin
            hi_cnt <= '0;
        end else if (hi_cnt < GW'(DIV)) begin
            hi_cnt <= hi_cnt + 1'b1;
        end
    end

    // R7
    idle_sck_low_chk: assert property (@(posedge clk) disable iff (rst)
        fl_cs_n |-> !fl_sck);

    // R7
    io0_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (!fl_cs_n && $past(!fl_cs_n) && fl_io0_o != $past(fl_io0_o)) |-> $fell(fl_sck));

    // R8
    stall_no_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (dout_valid && !dout_ready) |=> !$rose(fl_sck));

    // R9
    held_byte_chk: assert property (@(posedge clk) disable iff (rst)
        (dout_valid && !dout_ready) |=> (dout_valid && $stable(dout_data)));

    // R9
    done_after_end_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (fl_cs_n && !dout_valid));

    // R10
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (rst)
        !fl_cs_n |-> !req_ready);

    // R10
    cs_gap_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(fl_cs_n) |-> (hi_cnt >= GW'(DIV)));

endmodule

bind sfr_read_ctrl sfr_read_ctrl_chk #(.DIV(DIV)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_ready  (req_ready),
    .dout_valid (dout_valid),
    .dout_ready (dout_ready),
    .dout_data  (dout_data),
    .done       (done),
    .fl_sck     (fl_sck),
    .fl_cs_n    (fl_cs_n),
    .fl_io0_o   (fl_io0_o)
);

// File: tb/sim_sfr_read_ctrl.sv
`timescale 1ns/1ps
module sim_sfr_read_ctrl;
    localparam int DIV   = 4;
    localparam int LEN_W = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic [23:0]      req_addr = '0;
    logic [LEN_W-1:0] req_len = '0;
    logic [1:0]       req_mode = '0;
    logic             dout_valid;
    logic             dout_ready = 1'b1;
    logic [7:0]       dout_data;
    logic             done;
    logic             fl_sck, fl_cs_n, fl_io0_o, fl_io0_oe;
    logic             fl_io0_i = 1'b0;
    logic             fl_io1_i = 1'b0;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    sfr_read_ctrl #(.DIV(DIV), .LEN_W(LEN_W)) u0 (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_len(req_len), .req_mode(req_mode),
        .dout_valid(dout_valid), .dout_ready(dout_ready), .dout_data(dout_data),
        .done(done),
        .fl_sck(fl_sck), .fl_cs_n(fl_cs_n), .fl_io0_o(fl_io0_o), .fl_io0_oe(fl_io0_oe),
        .fl_io0_i(fl_io0_i), .fl_io1_i(fl_io1_i)
    );

    function automatic logic [7:0] memv(logic [15:0] a);
        return (a[7:0] * 8'd13) ^ a[15:8] ^ 8'h5C;
    endfunction

    // Flash model: 64 KiB array that wraps at its end.
    logic [7:0]  m_op = '0;
    logic [23:0] m_addr = '0;
    int          m_rise = 0;
    int          m_hdr = 32;
    bit          m_dual = 1'b0;
    int          m_oe_err = 0;
    int          m_xfers = 0;

    always @(negedge fl_cs_n or posedge fl_sck) begin
        if (!fl_sck) begin
            m_rise = 0; m_op = '0; m_addr = '0; m_hdr = 32; m_dual = 1'b0;
            m_oe_err = 0; m_xfers = m_xfers + 1;
        end else if (!fl_cs_n) begin
            if (m_rise < 8) m_op = {m_op[6:0], fl_io0_o};
            else if (m_rise < 32) m_addr = {m_addr[22:0], fl_io0_o};
            if (m_rise == 7) begin
                m_dual = (m_op == 8'h3B);
                m_hdr  = (m_op == 8'h03) ? 32 : 40;
            end
            if (m_rise < 32 && !fl_io0_oe) m_oe_err = m_oe_err + 1;
            if (m_rise >= 32 && m_dual && fl_io0_oe) m_oe_err = m_oe_err + 1;
            if (m_rise >= 32 && !m_dual && !fl_io0_oe) m_oe_err = m_oe_err + 1;
            m_rise = m_rise + 1;
        end
    end

    always @(negedge fl_sck) begin
        if (!fl_cs_n && m_rise >= m_hdr) begin
            automatic int k = m_rise - m_hdr;
            automatic logic [7:0] b;
            if (m_dual) begin
                b = memv(m_addr[15:0] + 16'(k / 4));
                fl_io1_i = b[7 - 2 * (k % 4)];
                fl_io0_i = b[6 - 2 * (k % 4)];
            end else begin
                b = memv(m_addr[15:0] + 16'(k / 8));
                fl_io1_i = b[7 - (k % 8)];
            end
        end
    end

    // Pin monitors
    logic p_sck = 1'b0, p_cs_n = 1'b1, p_io = 1'b0, p_stall = 1'b0;
    int   stall_viol = 0, fall_viol = 0, idle_viol = 0;
    int   hi_run = 0, last_gap = 1000;
    bit   seen_xfer = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            if (p_stall && !p_sck && fl_sck) stall_viol = stall_viol + 1;
            if (!p_cs_n && !fl_cs_n && fl_io0_o != p_io && !(p_sck && !fl_sck))
                fall_viol = fall_viol + 1;
            if (fl_cs_n && fl_sck) idle_viol = idle_viol + 1;
            if (p_cs_n && !fl_cs_n) begin
                if (seen_xfer) last_gap = hi_run;
                seen_xfer = 1'b1;
            end
            hi_run = fl_cs_n ? hi_run + 1 : 0;
        end
        p_sck = fl_sck; p_cs_n = fl_cs_n; p_io = fl_io0_o;
        p_stall = dout_valid && !dout_ready;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic test_reset();
        rst = 1'b1;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12
        chk(fl_cs_n === 1'b1 && fl_sck === 1'b0 && fl_io0_oe === 1'b0,
            "R12", "pins after reset", {fl_cs_n, fl_sck, fl_io0_oe}, 3'b100);
        chk(dout_valid === 1'b0 && done === 1'b0 && req_ready === 1'b1,
            "R12", "stream after reset", {dout_valid, done, req_ready}, 3'b001);
    endtask

    task automatic run_read(input logic [1:0] mode, input logic [23:0] addr,
                            input int n, input bit stall_on, input bit poke,
                            input bit settle, input string req);
        logic [7:0] got [0:15];
        int nget = 0;
        int cyc = 0;
        int ndone = 0;
        int xf0;
        int busy_seen_ready = 0;
        logic [7:0] exp_op;
        int per;
        stall_viol = 0; fall_viol = 0; idle_viol = 0;
        exp_op = (mode == 2'd1) ? 8'h0B : (mode == 2'd2) ? 8'h3B : 8'h03;
        per    = (mode == 2'd2) ? 4 : 8;
        @(negedge clk);
        xf0 = m_xfers;
        chk(req_ready === 1'b1, "R10", "ready when idle", req_ready, 1);
        req_valid = 1'b1; req_addr = addr; req_len = LEN_W'(n); req_mode = mode;
        @(negedge clk);
        req_valid = 1'b0;
        while (ndone == 0 && cyc < 20000) begin
            @(negedge clk);
            cyc = cyc + 1;
            if (poke) begin
                req_valid = (cyc >= 60 && cyc < 64);
                req_addr  = 24'hABCDEF;
                if (req_valid && req_ready) busy_seen_ready = busy_seen_ready + 1;
            end
            dout_ready = stall_on ? ((cyc % 41) > 25) : 1'b1;
            if (dout_valid && dout_ready) begin
                if (nget < 16) got[nget] = dout_data;
                nget = nget + 1;
            end
            if (done) ndone = ndone + 1;
        end
        req_valid = 1'b0;
        dout_ready = 1'b1;
        chk(ndone == 1, req, "done seen before timeout", ndone, 1);
        // R1
        chk(m_op == exp_op, "R1", "command byte", m_op, exp_op);
        // R2
        chk(m_addr == addr, "R2", "address", m_addr, addr);
        // R3
        chk(m_rise == m_hdr + n * per && m_hdr == ((mode == 2'd1 || mode == 2'd2) ? 40 : 32),
            "R3", "rising edges", m_rise, ((mode == 2'd1 || mode == 2'd2) ? 40 : 32) + n * per);
        // R9
        chk(nget == n, "R9", "byte count", nget, n);
        for (int i = 0; i < n && i < 16; i++) begin
            // R4 / R5 / R11
            chk(got[i] == memv(addr[15:0] + 16'(i)), req, "data byte", got[i],
                memv(addr[15:0] + 16'(i)));
        end
        // R6
        chk(m_oe_err == 0, "R6", "io0 drive enable errors", m_oe_err, 0);
        // R7
        chk(fall_viol == 0 && idle_viol == 0, "R7", "clock and io0 timing",
            fall_viol + idle_viol, 0);
        // R8
        chk(stall_viol == 0, "R8", "rise while stalled", stall_viol, 0);
        if (settle) begin
            int extra = 0;
            repeat (12) begin
                @(negedge clk);
                if (done || dout_valid) extra = extra + 1;
            end
            // R9
            chk(extra == 0, "R9", "no output after done", extra, 0);
            // R10
            chk(m_xfers == xf0 + 1, "R10", "transfers started", m_xfers - xf0, 1);
        end
        if (poke) chk(busy_seen_ready == 0, "R10", "ready while busy", busy_seen_ready, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        $display("FAIL watchdog R9 actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
        $finish;
    end

    initial begin
        test_reset();
        run_read(2'd0, 24'h012345, 5, 1'b0, 1'b0, 1'b1, "R4");
        run_read(2'd1, 24'h00ABCD, 3, 1'b0, 1'b0, 1'b1, "R4");
        run_read(2'd2, 24'h004321, 6, 1'b0, 1'b0, 1'b1, "R5");
        run_read(2'd2, 24'h00FFFE, 4, 1'b0, 1'b0, 1'b1, "R11");
        run_read(2'd0, 24'h00FFFF, 3, 1'b0, 1'b0, 1'b1, "R11");
        run_read(2'd1, 24'h000777, 5, 1'b1, 1'b0, 1'b1, "R8");
        run_read(2'd2, 24'h0013A0, 5, 1'b1, 1'b0, 1'b1, "R8");
        run_read(2'd0, 24'h002000, 4, 1'b0, 1'b1, 1'b1, "R10");
        run_read(2'd3, 24'h003456, 2, 1'b0, 1'b0, 1'b0, "R1");
        run_read(2'd2, 24'h000010, 1, 1'b0, 1'b0, 1'b1, "R5");
        // R10
        chk(last_gap >= DIV, "R10", "chip select high gap", last_gap, DIV);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule